// File: doc/BRIEF.md
# Parallel Flash Byte Programmer

This controller sits on the host side of a byte-wide parallel flash device. It takes one request at a time over a valid/ready handshake. A request is a whole-chip erase, a single-byte program, or a single-byte read. The controller turns each request into bus cycles on the device pins: chip enable, output enable, write enable, an address bus and a split data bus (output, output-enable and input).

A program or erase begins with the fixed unlock write prefix that the device expects. The controller then polls the device with read cycles until the operation is complete, rather than waiting for a fixed time:

- **Program:** completion is detected when bit 7 of the read data matches the written data.
- **Erase:** completion is detected when bit 6 returns the same value on two consecutive reads.

Before a program, the controller reads the target byte. If the new value would need any bit to go from 0 to 1, the request is rejected with an error, because only an erase can set bits. The response pulse carries:

- an error flag;
- a timeout flag, raised when polling reaches its limit;
- the last byte read.

Write-enable width, read width and the poll limit are clock-count parameters. The address bus must be at least 15 bits wide so that it can carry the unlock addresses.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Out of reset, `req_ready` is 1, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, and `fl_dq_oe` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 through a single-cycle `rsp_valid` pulse. `req_ready` returns to 1 in the cycle after that pulse.
- R3: Op code 2'b00 is a read. It performs one read cycle at `req_addr`, issues no write cycle, and returns the byte on `rsp_rdata`.
- R4: Op code 2'b01 is a program. After its pre-read it issues four write cycles, as (address, data) pairs: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`req_addr`, `req_wdata`).
- R5: Op code 2'b10 or 2'b11 is a chip erase. It issues six write cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R6: Every write cycle has the following shape:
  - `fl_ce_n` falls at least one clock before `fl_we_n` falls.
  - `fl_we_n` is low for exactly WE_CLKS clocks.
  - `fl_oe_n` stays high and the address stays stable throughout.
  - Data is still driven, with `fl_ce_n` low, in the clock where `fl_we_n` rises.
- R7: `fl_dq_oe` is never 1 while `fl_oe_n` is 0. Every write cycle is followed by a clock with `fl_ce_n` high and `fl_dq_oe` low.
- R8: A program first reads the target byte. If (~current & new) is non-zero, the response has `rsp_err`=1, no write cycle is issued, and `rsp_rdata` is the current byte.
- R9: After the program writes, the target address is polled until read bit 7 equals `req_wdata` bit 7. The response then has no error flag and carries the last byte read.
- R10: After the erase writes, `req_addr` is polled until two consecutive reads agree on bit 6. The response then has no error flag.
- R11: If completion is not seen within MAX_POLL poll reads, the response has `rsp_timeout`=1, and exactly MAX_POLL poll reads have been made.
- R12: In every read cycle, `fl_ce_n` and `fl_oe_n` are low together for exactly RD_CLKS clocks, with `fl_we_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_op | input | 2 | 00 read, 01 program, 1x chip erase |
| req_addr | input | AW | Byte address (also the erase poll address) |
| req_wdata | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Program rejected (0-to-1 change needed) |
| rsp_timeout | output | 1 | Poll limit reached |
| rsp_rdata | output | 8 | Last byte read from the device |
| fl_ce_n | output | 1 | Device chip enable, active low |
| fl_oe_n | output | 1 | Device output enable, active low |
| fl_we_n | output | 1 | Device write enable, active low |
| fl_addr | output | AW | Device address |
| fl_dq_o | output | 8 | Data driven toward the device |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_i | input | 8 | Data from the device |

## Verification
The bench pairs the controller with a device model and checks the following corner cases:

- **Unlock sequences.** The model only acts on exact unlock sequences. A wrong address or data byte in any unlock step leaves the memory untouched, so later reads show stale data or the poll times out.
- **Reprogramming.** Each byte is reprogrammed with a second value. Some of these values need a 0-to-1 change and some are strict subsets. A controller that skipped or misjudged the pre-read would either issue writes that should never happen or reject a legal clearing of bits.
- **Erase completion.** The model's bit 6 toggles on every busy read. An erase check that accepted a single read, or compared the wrong bit, would end early and read back non-erased bytes.
- **Stuck device.** A stuck-busy model tests the poll limit: an off-by-one shows up as the wrong number of poll reads.
- **Pin protocol.** The model measures strobe widths, read widths and bus turnaround, which exposes timing or contention slips.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int AW       = 17,
  parameter int WE_CLKS  = 4,
  parameter int RD_CLKS  = 3,
  parameter int MAX_POLL = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic          rsp_timeout,
  output logic [7:0]    rsp_rdata,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i
);
  localparam int CMAX = (WE_CLKS > RD_CLKS) ? WE_CLKS : RD_CLKS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int PW   = $clog2(MAX_POLL + 1);
  localparam logic [AW-1:0] UA1 = AW'(15'h5555);
  localparam logic [AW-1:0] UA2 = AW'(15'h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_WSU, S_WLO, S_WHI, S_RD, S_GAP, S_RESP} state_t;
  typedef enum logic [1:0] {P_PRE, P_WR, P_POLL} phase_t;

  state_t          state;
  phase_t          phase;
  logic [1:0]      op_r;
  logic [AW-1:0]   addr_r;
  logic [7:0]      data_r;
  logic [2:0]      wi;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   polls;
  logic            last6, fin, err_r, tmo_r;
  logic [7:0]      rdata_r;
  logic [AW-1:0]   wr_addr;
  logic [7:0]      wr_data;

  wire is_erase = op_r[1];
  wire is_prog  = (op_r == 2'b01);
  wire [2:0] last_wi = is_erase ? 3'd5 : 3'd3;
  wire rd_last = (cnt == CW'(RD_CLKS - 1));
  wire done_hit = is_erase ? (polls != '0 && fl_dq_i[6] == last6)
                           : (fl_dq_i[7] == data_r[7]);

  always_comb begin
    wr_addr = UA1;
    wr_data = 8'h10;
    case (wi)
      3'd0: begin wr_addr = UA1; wr_data = 8'hAA; end
      3'd1: begin wr_addr = UA2; wr_data = 8'h55; end
      3'd2: begin wr_addr = UA1; wr_data = is_erase ? 8'h80 : 8'hA0; end
      3'd3: begin
        wr_addr = is_erase ? UA1   : addr_r;
        wr_data = is_erase ? 8'hAA : data_r;
      end
      3'd4: begin wr_addr = UA2; wr_data = 8'h55; end
      default: begin wr_addr = UA1; wr_data = 8'h10; end
    endcase
  end

  assign req_ready   = (state == S_IDLE);
  assign rsp_valid   = (state == S_RESP);
  assign rsp_err     = rsp_valid & err_r;
  assign rsp_timeout = rsp_valid & tmo_r;
  assign rsp_rdata   = rdata_r;

  assign fl_ce_n  = !(state inside {S_WSU, S_WLO, S_WHI, S_RD});
  assign fl_we_n  = (state != S_WLO);
  assign fl_oe_n  = (state != S_RD);
  assign fl_dq_oe = (state inside {S_WSU, S_WLO, S_WHI});
  assign fl_addr  = (phase == P_WR) ? wr_addr : addr_r;
  assign fl_dq_o  = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= P_PRE;
      op_r    <= '0;
      addr_r  <= '0;
      data_r  <= '0;
      wi      <= '0;
      cnt     <= '0;
      polls   <= '0;
      last6   <= 1'b0;
      fin     <= 1'b0;
      err_r   <= 1'b0;
      tmo_r   <= 1'b0;
      rdata_r <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          op_r   <= req_op;
          addr_r <= req_addr;
          data_r <= req_wdata;
          wi     <= '0;
          cnt    <= '0;
          polls  <= '0;
          fin    <= 1'b0;
          err_r  <= 1'b0;
          tmo_r  <= 1'b0;
          if (req_op[1]) begin
            phase <= P_WR;
            state <= S_WSU;
          end else begin
            phase <= P_PRE;
            state <= S_RD;
          end
        end
        S_WSU: state <= S_WLO;
        S_WLO: if (cnt == CW'(WE_CLKS - 1)) begin
          cnt   <= '0;
          state <= S_WHI;
        end else cnt <= cnt + 1'b1;
        S_WHI: begin
          state <= S_GAP;
          if (wi == last_wi) begin
            phase <= P_POLL;
            polls <= '0;
          end else wi <= wi + 1'b1;
        end
        S_RD: if (!rd_last) cnt <= cnt + 1'b1;
        else begin
          cnt     <= '0;
          state   <= S_GAP;
          rdata_r <= fl_dq_i;
          if (phase == P_PRE) begin
            if (!is_prog) fin <= 1'b1;
            else if (|(~fl_dq_i & data_r)) begin
              err_r <= 1'b1;
              fin   <= 1'b1;
            end else phase <= P_WR;
          end else begin
            polls <= polls + 1'b1;
            last6 <= fl_dq_i[6];
            if (done_hit) fin <= 1'b1;
            else if (polls == PW'(MAX_POLL - 1)) begin
              tmo_r <= 1'b1;
              fin   <= 1'b1;
            end
          end
        end
        S_GAP: state <= fin ? S_RESP : ((phase == P_WR) ? S_WSU : S_RD);
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int AW      = 17,
  parameter int WE_CLKS = 4,
  parameter int RD_CLKS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dq_o,
  input logic          fl_dq_oe
);
  int we_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= 0;
      oe_run <= 0;
    end else begin
      we_run <= fl_we_n ? 0 : we_run + 1;
      oe_run <= fl_oe_n ? 0 : oe_run + 1;
    end
  end

  // R2
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_dq_oe && !fl_oe_n));
  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_dq_oe) |-> fl_ce_n);
  // R6
  we_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> ($past(!fl_ce_n) && fl_oe_n && fl_dq_oe));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (fl_dq_oe && !fl_ce_n && $stable(fl_dq_o)));
  // R6
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (we_run == WE_CLKS));
  // R12
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_oe_n) |-> (oe_run == RD_CLKS));
  // R12
  rd_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_ce_n && fl_we_n));
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.AW(AW), .WE_CLKS(WE_CLKS), .RD_CLKS(RD_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
  .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
);

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;
  localparam int AW = 17, WE = 3, RD = 2, MP = 12;
  localparam int PROG_T = 15, ERASE_T = 24;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_err, rsp_timeout;
  logic [7:0] rsp_rdata;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_o, fl_dq_i;

  always #2 clk = ~clk;

  flash_prog_ctrl #(.AW(AW), .WE_CLKS(WE), .RD_CLKS(RD), .MAX_POLL(MP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_timeout(rsp_timeout),
    .rsp_rdata(rsp_rdata), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i));

  // device model
  logic [7:0] mem [32];
  logic stuck = 0;
  int busy, bkind, cpos, wr_cnt, rd_cnt, prog_cnt, erase_cnt, pe6, pe7, pe12, we_run, oe_run;
  logic prev_we, prev_oe, prev_ce, gap_due, tog;
  logic [7:0] pdata;
  logic [AW-1:0] we_addr;

  always_comb begin
    if (fl_ce_n || fl_oe_n) fl_dq_i = 8'h00;
    else if (busy > 0 && bkind == 0) fl_dq_i = {~pdata[7], tog, pdata[5:0]};
    else if (busy > 0) fl_dq_i = {1'b0, tog, 6'h0};
    else fl_dq_i = mem[fl_addr[4:0]];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= 8'(i * 13 + 1);
      busy <= 0; bkind <= 0; cpos <= 0; wr_cnt <= 0; rd_cnt <= 0; prog_cnt <= 0;
      erase_cnt <= 0; pe6 <= 0; pe7 <= 0; pe12 <= 0; we_run <= 0; oe_run <= 0;
      prev_we <= 1; prev_oe <= 1; prev_ce <= 1; gap_due <= 0; tog <= 0; pdata <= 0; we_addr <= 0;
    end else begin
      prev_we <= fl_we_n; prev_oe <= fl_oe_n; prev_ce <= fl_ce_n;
      we_run <= fl_we_n ? 0 : we_run + 1;
      oe_run <= fl_oe_n ? 0 : oe_run + 1;
      if (busy > 0 && !stuck) busy <= busy - 1;
      if (fl_dq_oe && !fl_oe_n) pe7 <= pe7 + 1;
      if (gap_due) begin
        gap_due <= 0;
        if (!fl_ce_n || fl_dq_oe) pe7 <= pe7 + 1;
      end
      if (!fl_oe_n && (fl_ce_n || !fl_we_n)) pe12 <= pe12 + 1;
      if (prev_oe == 0 && fl_oe_n == 1) begin
        tog <= ~tog;
        rd_cnt <= rd_cnt + 1;
        if (oe_run != RD) pe12 <= pe12 + 1;
      end
      if (!fl_we_n && prev_we) begin
        we_addr <= fl_addr;
        if (prev_ce || !fl_oe_n) pe6 <= pe6 + 1;
      end
      if (!prev_we && fl_we_n) begin
        wr_cnt <= wr_cnt + 1;
        gap_due <= 1;
        if (we_run != WE || fl_ce_n || !fl_oe_n || !fl_dq_oe || fl_addr != we_addr) pe6 <= pe6 + 1;
        if (busy == 0) begin
          case (cpos)
            0: cpos <= (fl_addr == 17'h5555 && fl_dq_o == 8'hAA) ? 1 : 0;
            1: cpos <= (fl_addr == 17'h2AAA && fl_dq_o == 8'h55) ? 2 : 0;
            2: cpos <= (fl_addr != 17'h5555) ? 0 : (fl_dq_o == 8'hA0) ? 6 : (fl_dq_o == 8'h80) ? 3 : 0;
            3: cpos <= (fl_addr == 17'h5555 && fl_dq_o == 8'hAA) ? 4 : 0;
            4: cpos <= (fl_addr == 17'h2AAA && fl_dq_o == 8'h55) ? 5 : 0;
            5: begin
              cpos <= 0;
              if (fl_addr == 17'h5555 && fl_dq_o == 8'h10) begin
                for (int i = 0; i < 32; i++) mem[i] <= 8'hFF;
                busy <= ERASE_T; bkind <= 1; erase_cnt <= erase_cnt + 1;
              end
            end
            default: begin
              cpos <= 0;
              mem[fl_addr[4:0]] <= mem[fl_addr[4:0]] & fl_dq_o;
              pdata <= fl_dq_o; busy <= PROG_T; bkind <= 0; prog_cnt <= prog_cnt + 1;
            end
          endcase
        end
      end
    end
  end

  int checks = 0, errors = 0;
  logic [7:0] v1 [32];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic r_err, r_tmo;
  logic [7:0] r_data;

  task automatic do_req(input logic [1:0] op, input int a, input logic [7:0] d);
    int n;
    @(negedge clk);
    chk(req_ready == 1, "R2", "ready before request", req_ready, 1);
    req_valid = 1; req_op = op; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2", "ready after accept", req_ready, 0);
    n = 0;
    while (!rsp_valid && n < 5000) begin
      @(negedge clk);
      n++;
      if (!rsp_valid && req_ready) chk(0, "R2", "ready during operation", 1, 0);
    end
    r_err = rsp_err; r_tmo = rsp_timeout; r_data = rsp_rdata;
    chk(rsp_valid == 1, "R2", "response seen", rsp_valid, 1);
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R2", "pulse ends and ready returns",
        {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R1", "reset pins",
        {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 5'b11110);
    rst_n = 1;
    repeat (2) @(negedge clk);

    begin : erase1
      int w0, e0;
      w0 = wr_cnt; e0 = erase_cnt;
      do_req(2'b10, 0, 0);
      chk(!r_err && !r_tmo, "R10", "erase status", {r_err, r_tmo}, 0);
      chk(wr_cnt - w0 == 6, "R5", "erase write count", wr_cnt - w0, 6);
      chk(erase_cnt - e0 == 1, "R5", "erase sequence accepted", erase_cnt - e0, 1);
      chk(busy == 0, "R10", "erase finished before response", busy, 0);
    end

    for (int a = 0; a < 32; a++) begin
      int w0;
      w0 = wr_cnt;
      do_req(2'b00, a, 0);
      chk(r_data == 8'hFF, "R3", "read after erase", r_data, 8'hFF);
      chk(wr_cnt == w0, "R3", "read issues no write", wr_cnt - w0, 0);
    end

    for (int a = 0; a < 32; a++) begin
      int w0, p0;
      logic [7:0] v;
      v = 8'((a * 37 + 11) ^ (a << 3));
      v1[a] = v;
      w0 = wr_cnt; p0 = prog_cnt;
      do_req(2'b01, a, v);
      chk(!r_err && !r_tmo, "R9", "program status", {r_err, r_tmo}, 0);
      chk(r_data == v, "R9", "program poll data", r_data, v);
      chk(wr_cnt - w0 == 4, "R4", "program write count", wr_cnt - w0, 4);
      chk(prog_cnt - p0 == 1, "R4", "program sequence accepted", prog_cnt - p0, 1);
    end

    for (int a = 0; a < 32; a++) begin
      do_req(2'b00, a, 0);
      chk(r_data == v1[a], "R3", "read after program", r_data, v1[a]);
    end

    for (int a = 0; a < 32; a++) begin
      int w0;
      logic [7:0] v2, expv;
      bit experr;
      v2 = (a % 4 == 0) ? (v1[a] & 8'(a * 5)) : 8'(a * 91 + 3);
      experr = |(v2 & ~v1[a]);
      w0 = wr_cnt;
      do_req(2'b01, a, v2);
      if (experr) begin
        chk(r_err == 1 && r_tmo == 0, "R8", "reject 0-to-1", {r_err, r_tmo}, 2'b10);
        chk(wr_cnt == w0, "R8", "rejected program writes nothing", wr_cnt - w0, 0);
        chk(r_data == v1[a], "R8", "rejected program returns current", r_data, v1[a]);
        expv = v1[a];
      end else begin
        chk(r_err == 0 && r_tmo == 0, "R8", "subset program accepted", {r_err, r_tmo}, 0);
        chk(r_data == v2, "R9", "reprogram poll data", r_data, v2);
        expv = v2;
      end
      do_req(2'b00, a, 0);
      chk(r_data == expv, "R8", "read after reprogram", r_data, expv);
    end

    begin : stuck_erase
      int r0;
      stuck = 1;
      r0 = rd_cnt;
      do_req(2'b11, 3, 0);
      chk(r_tmo == 1 && r_err == 0, "R11", "erase timeout", {r_err, r_tmo}, 2'b01);
      chk(rd_cnt - r0 == MP, "R11", "erase poll count", rd_cnt - r0, MP);
      stuck = 0;
      repeat (ERASE_T + 5) @(negedge clk);
    end

    for (int a = 0; a < 32; a++) begin
      do_req(2'b00, a, 0);
      chk(r_data == 8'hFF, "R5", "read after second erase", r_data, 8'hFF);
    end

    begin : stuck_prog
      int r0;
      stuck = 1;
      r0 = rd_cnt;
      do_req(2'b01, 5, 8'h3C);
      chk(r_tmo == 1 && r_err == 0, "R11", "program timeout", {r_err, r_tmo}, 2'b01);
      chk(rd_cnt - r0 == MP + 1, "R11", "program pre-read plus polls", rd_cnt - r0, MP + 1);
      stuck = 0;
      repeat (PROG_T + 5) @(negedge clk);
      do_req(2'b00, 5, 0);
      chk(r_data == 8'h3C, "R4", "stuck program data landed", r_data, 8'h3C);
    end

    chk(pe6 == 0, "R6", "write cycle shape faults", pe6, 0);
    chk(pe7 == 0, "R7", "bus turnaround faults", pe7, 0);
    chk(pe12 == 0, "R12", "read cycle shape faults", pe12, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule